// File: doc/BRIEF.md
# Triangle Scanline Count Setup

This block is the first stage of a triangle setup pipeline. It accepts three screen-space vertices, each with an x and y coordinate in IEEE-754 single precision and a 24-bit colour. The coordinates lie in a normalized space in which 0.0 is the top or left edge of the screen, 0.5 is the middle, and 1.0 is the bottom or right edge. Vertex A is always the top vertex. B sits bottom-left and C sits bottom-right. The block decides which of B and C is lower and takes the vertical span from A down to that vertex. It scales the span to a framebuffer that is `ROWS` lines tall (240 by default) and produces the integer number of raster lines the triangle covers.

The work is a five-stage pipeline with a fixed latency:
1. Classify and select.
2. Convert to fixed point.
3. Subtract.
4. Multiply by the row count.
5. Truncate and clamp.

A new triangle may enter on every clock cycle. The positions and colours travel down a matching delay line, so every result leaves together with the vertex data it was computed from. A small control module shifts the valid strobe along and hands the per-stage load enables to the datapath. No state machine schedules the arithmetic.

Floats use the standard single-precision layout: sign in bit 31, biased exponent in bits 30:23, mantissa in bits 22:0. Colours are packed as {red[23:16], green[15:8], blue[7:0]}.

Top module: `tri_rowspan_setup`

## Requirements
- R1: A triangle sampled with `inValid` high on a rising edge appears with `outValid` high after the fifth rising edge, counting the sampling edge as the first. `outValid` is low on the cycle before and on the cycle after. Triangles on consecutive cycles leave on consecutive cycles.
- R2: All six position words and all three colour words leave unchanged, alongside the result of the same triangle.
- R3: The bottom vertex X is C when C's y is strictly greater than B's y, and B otherwise (a tie picks B). `bottomIsC` is 1 exactly when C is picked.
- R4: `lineCount` equals floor((yX - yA) * ROWS). Each y is first converted to unsigned fixed point with `FRAC_W` fraction bits, truncating toward zero. For example, yA=0.25 and yX=0.75 give 120, and yA=0.0 and yX=2^-7 give 1.
- R5: When yX is at or above yA on screen (yX <= yA), `lineCount` is 0 and `rangeErr` stays 0. A full span from 0.0 to 1.0 gives exactly ROWS (240).
- R6: A y with exponent field 0 (a denormal, +0.0 or -0.0) is treated as 0.0 and does not raise `rangeErr`.
- R7: If any of the three y inputs is NaN or infinity (exponent field 255), is negative and non-zero, or is greater than 1.0 (bits above 0x3F800000), then `lineCount` is 0 and `rangeErr` is 1.
- R8: While `rstN` is low, `outValid`, `lineCount` and `rangeErr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A triangle is presented this cycle |
| posAx | input | 32 | Vertex A x, single precision |
| posAy | input | 32 | Vertex A y, single precision |
| posBx | input | 32 | Vertex B x |
| posBy | input | 32 | Vertex B y |
| posCx | input | 32 | Vertex C x |
| posCy | input | 32 | Vertex C y |
| colA | input | 24 | Vertex A colour {r,g,b} |
| colB | input | 24 | Vertex B colour {r,g,b} |
| colC | input | 24 | Vertex C colour {r,g,b} |
| outValid | output | 1 | Result and delayed vertex data are valid |
| lineCount | output | COUNT_W | Raster lines covered, 0 to ROWS |
| rangeErr | output | 1 | A y input was NaN, infinite, negative or above 1.0 |
| bottomIsC | output | 1 | 1 when C was taken as the bottom vertex |
| outPosAx | output | 32 | Delayed vertex A x |
| outPosAy | output | 32 | Delayed vertex A y |
| outPosBx | output | 32 | Delayed vertex B x |
| outPosBy | output | 32 | Delayed vertex B y |
| outPosCx | output | 32 | Delayed vertex C x |
| outPosCy | output | 32 | Delayed vertex C y |
| outColA | output | 24 | Delayed vertex A colour |
| outColB | output | 24 | Delayed vertex B colour |
| outColC | output | 24 | Delayed vertex C colour |

## Verification
The bench targets the following corner cases:
- **Tie between B and C.** A design that compares with `>=` would report C.
- **Tiny span of 2^-7.** This must give one line. A design that rounds, or that loses low fixed-point bits, would give 2 or 0.
- **Full 0.0-to-1.0 span.** This must give exactly 240. A design with an off-by-one clamp or a narrow product would give 239 or would wrap.
- **Inverted span.** A design that forgets to clamp the subtraction at zero would return a large wrapped count for this case.
- **Signed zeros and denormals.** A design that does not flush these would raise a false error or leave a stray span.
- **Bad y inputs.** NaN, infinity, negative values and the value just above 1.0 are each placed on a different vertex. A design that checks only some of the three y inputs would leave a count standing for the rest.
- **Streaming.** Three triangles are sent back to back. A misaligned side delay line shows up as mismatched positions or colours.

// File: rtl/rowspan_pkg.sv
package rowspan_pkg;

  localparam int STAGES = 5;

  typedef struct packed {
    logic [31:0] ax;
    logic [31:0] ay;
    logic [31:0] bx;
    logic [31:0] by;
    logic [31:0] cx;
    logic [31:0] cy;
    logic [23:0] ca;
    logic [23:0] cb;
    logic [23:0] cc;
  } sideT;

  typedef struct packed {
    logic [STAGES-1:0] load;
  } strobeT;

endpackage

// File: rtl/rowspan_ctrl.sv
module rowspan_ctrl
  import rowspan_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   inValid,
  output strobeT stb,
  output logic   outValid
);

  localparam int CNT_W = $clog2(STAGES + 1);

  logic [STAGES-1:0] vld;
  logic [CNT_W-1:0]  sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld <= '0;
    end else begin
      vld <= {vld[STAGES-2:0], inValid};
    end
  end

  always_comb begin
    stb.load = {vld[STAGES-2:0], inValid};
  end

  assign outValid = vld[STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= '0;
    end else if (sinceRst != CNT_W'(STAGES)) begin
      sinceRst <= sinceRst + 1'b1;
    end
  end

  assert_fixed_latency_R1 : assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == CNT_W'(STAGES)) |-> (outValid == $past(inValid, STAGES)));

endmodule

// File: rtl/rowspan_delay.sv
module rowspan_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DEPTH-1:0] load,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout
);

  logic [W-1:0] pipe [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_tap
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        pipe[i] <= '0;
        else if (load[i]) pipe[i] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        pipe[i] <= '0;
        else if (load[i]) pipe[i] <= pipe[i-1];
      end
    end
  end

  assign dout = pipe[DEPTH-1];

endmodule

// File: rtl/rowspan_dpath.sv
module rowspan_dpath
  import rowspan_pkg::*;
#(
  parameter int FRAC_W  = 32,
  parameter int ROWS    = 240,
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             stb,
  input  logic               outValid,
  input  logic [31:0]        yA,
  input  logic [31:0]        yB,
  input  logic [31:0]        yC,
  output logic [COUNT_W-1:0] lineCount,
  output logic               rangeErr,
  output logic               bottomIsC
);

  localparam int FX_W   = FRAC_W + 1;
  localparam int WIDE_W = 24 + FRAC_W;
  localparam int PROD_W = FX_W + COUNT_W + 1;

  function automatic logic isBad(input logic [31:0] v);
    logic expMax, expZero;
    expMax  = (v[30:23] == 8'hFF);
    expZero = (v[30:23] == 8'h00);
    return expMax || (v[31] && !expZero) || (!v[31] && (v[30:0] > 31'h3F800000));
  endfunction

  function automatic logic [31:0] flushZero(input logic [31:0] v);
    return (v[30:23] == 8'h00) ? 32'h0 : v;
  endfunction

  function automatic logic [FX_W-1:0] toFixed(input logic [31:0] v);
    logic [WIDE_W-1:0] wide;
    logic [WIDE_W-1:0] shifted;
    int                sh;
    if (v[30:23] == 8'h00) return '0;
    if (v[30:23] >= 8'd127) return FX_W'(1) << FRAC_W;
    wide    = {1'b1, v[22:0], {FRAC_W{1'b0}}};
    sh      = 150 - int'(v[30:23]);
    shifted = wide >> sh;
    return shifted[FX_W-1:0];
  endfunction

  // stage 1: classify, flush, pick bottom vertex
  logic [31:0] fA, fB, fC;
  logic        pickC, anyBad;
  logic [31:0] s1YA, s1YX;
  logic        s1Bad, s1SelC;

  always_comb begin
    fA     = flushZero(yA);
    fB     = flushZero(yB);
    fC     = flushZero(yC);
    pickC  = fC[30:0] > fB[30:0];
    anyBad = isBad(yA) || isBad(yB) || isBad(yC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1YA <= '0; s1YX <= '0; s1Bad <= 1'b0; s1SelC <= 1'b0;
    end else if (stb.load[0]) begin
      s1YA   <= fA;
      s1YX   <= pickC ? fC : fB;
      s1Bad  <= anyBad;
      s1SelC <= pickC;
    end
  end

  // stage 2: float to fixed point
  logic [FX_W-1:0] s2FxA, s2FxX;
  logic            s2Bad, s2SelC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2FxA <= '0; s2FxX <= '0; s2Bad <= 1'b0; s2SelC <= 1'b0;
    end else if (stb.load[1]) begin
      s2FxA  <= toFixed(s1YA);
      s2FxX  <= toFixed(s1YX);
      s2Bad  <= s1Bad;
      s2SelC <= s1SelC;
    end
  end

  assert_flush_R6 : assert property (@(posedge clk) disable iff (!rstN)
    (stb.load[1] && s1YA[30:23] == 8'h00) |=> (s2FxA == '0));

  // stage 3: subtract, floor at zero
  logic [FX_W-1:0] s3Diff;
  logic            s3Bad, s3SelC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s3Diff <= '0; s3Bad <= 1'b0; s3SelC <= 1'b0;
    end else if (stb.load[2]) begin
      s3Diff <= (s2FxX > s2FxA) ? (s2FxX - s2FxA) : '0;
      s3Bad  <= s2Bad;
      s3SelC <= s2SelC;
    end
  end

  // stage 4: scale by framebuffer height
  logic [PROD_W-1:0] s4Prod;
  logic              s4Bad, s4SelC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s4Prod <= '0; s4Bad <= 1'b0; s4SelC <= 1'b0;
    end else if (stb.load[3]) begin
      s4Prod <= PROD_W'(s3Diff) * PROD_W'(ROWS);
      s4Bad  <= s3Bad;
      s4SelC <= s3SelC;
    end
  end

  // stage 5: truncate to integer, clamp, apply error
  logic [PROD_W-1:0] whole;
  logic [COUNT_W-1:0] capped;

  always_comb begin
    whole  = s4Prod >> FRAC_W;
    capped = (whole > PROD_W'(ROWS)) ? COUNT_W'(ROWS) : whole[COUNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineCount <= '0; rangeErr <= 1'b0; bottomIsC <= 1'b0;
    end else if (stb.load[4]) begin
      lineCount <= s4Bad ? '0 : capped;
      rangeErr  <= s4Bad;
      bottomIsC <= s4SelC;
    end
  end

  assert_count_cap_R5 : assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (lineCount <= COUNT_W'(ROWS)));

endmodule

// File: rtl/tri_rowspan_setup.sv
module tri_rowspan_setup
  import rowspan_pkg::*;
#(
  parameter int FRAC_W  = 32,
  parameter int ROWS    = 240,
  parameter int COUNT_W = $clog2(ROWS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [31:0]        posAx,
  input  logic [31:0]        posAy,
  input  logic [31:0]        posBx,
  input  logic [31:0]        posBy,
  input  logic [31:0]        posCx,
  input  logic [31:0]        posCy,
  input  logic [23:0]        colA,
  input  logic [23:0]        colB,
  input  logic [23:0]        colC,
  output logic               outValid,
  output logic [COUNT_W-1:0] lineCount,
  output logic               rangeErr,
  output logic               bottomIsC,
  output logic [31:0]        outPosAx,
  output logic [31:0]        outPosAy,
  output logic [31:0]        outPosBx,
  output logic [31:0]        outPosBy,
  output logic [31:0]        outPosCx,
  output logic [31:0]        outPosCy,
  output logic [23:0]        outColA,
  output logic [23:0]        outColB,
  output logic [23:0]        outColC
);

  strobeT stb;
  sideT   sideIn, sideOut;

  rowspan_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  rowspan_dpath #(
    .FRAC_W  (FRAC_W),
    .ROWS    (ROWS),
    .COUNT_W (COUNT_W)
  ) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .outValid  (outValid),
    .yA        (posAy),
    .yB        (posBy),
    .yC        (posCy),
    .lineCount (lineCount),
    .rangeErr  (rangeErr),
    .bottomIsC (bottomIsC)
  );

  always_comb begin
    sideIn = '{ax: posAx, ay: posAy, bx: posBx, by: posBy, cx: posCx, cy: posCy,
               ca: colA, cb: colB, cc: colC};
  end

  rowspan_delay #(
    .W     ($bits(sideT)),
    .DEPTH (STAGES)
  ) i_side (
    .clk  (clk),
    .rstN (rstN),
    .load (stb.load),
    .din  (sideIn),
    .dout (sideOut)
  );

  assign outPosAx = sideOut.ax;
  assign outPosAy = sideOut.ay;
  assign outPosBx = sideOut.bx;
  assign outPosBy = sideOut.by;
  assign outPosCx = sideOut.cx;
  assign outPosCy = sideOut.cy;
  assign outColA  = sideOut.ca;
  assign outColB  = sideOut.cb;
  assign outColC  = sideOut.cc;

  assert_err_zero_R7 : assert property (@(posedge clk) disable iff (!rstN)
    (outValid && rangeErr) |-> (lineCount == '0));

  assert_bottom_pick_R3 : assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !rangeErr) |->
      (bottomIsC ? (outPosCy[30:23] != 8'h00 && outPosCy[30:0] > outPosBy[30:0])
                 : (outPosCy[30:23] == 8'h00 || outPosCy[30:0] <= outPosBy[30:0])));

endmodule

// File: tb/test_tri_rowspan_setup.sv
module test_tri_rowspan_setup;

  localparam logic [31:0] F0    = 32'h00000000;
  localparam logic [31:0] FNEG0 = 32'h80000000;
  localparam logic [31:0] FDEN1 = 32'h00000001;
  localparam logic [31:0] FDENM = 32'h007FFFFF;
  localparam logic [31:0] F2M7  = 32'h3C000000;
  localparam logic [31:0] F0125 = 32'h3E000000;
  localparam logic [31:0] F025  = 32'h3E800000;
  localparam logic [31:0] F0375 = 32'h3EC00000;
  localparam logic [31:0] F05   = 32'h3F000000;
  localparam logic [31:0] F0625 = 32'h3F200000;
  localparam logic [31:0] F075  = 32'h3F400000;
  localparam logic [31:0] F1    = 32'h3F800000;
  localparam logic [31:0] FOVER = 32'h3F800001;
  localparam logic [31:0] FNAN  = 32'h7FC00000;
  localparam logic [31:0] FINF  = 32'h7F800000;
  localparam logic [31:0] FM025 = 32'hBE800000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] posAx = '0, posAy = '0, posBx = '0, posBy = '0, posCx = '0, posCy = '0;
  logic [23:0] colA = '0, colB = '0, colC = '0;
  logic        outValid, rangeErr, bottomIsC;
  logic [7:0]  lineCount;
  logic [31:0] outPosAx, outPosAy, outPosBx, outPosBy, outPosCx, outPosCy;
  logic [23:0] outColA, outColB, outColC;

  int checks = 0;
  int fails  = 0;
  int seq    = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tri_rowspan_setup i_tri_rowspan_setup (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .posAx(posAx), .posAy(posAy), .posBx(posBx), .posBy(posBy),
    .posCx(posCx), .posCy(posCy), .colA(colA), .colB(colB), .colC(colC),
    .outValid(outValid), .lineCount(lineCount), .rangeErr(rangeErr),
    .bottomIsC(bottomIsC),
    .outPosAx(outPosAx), .outPosAy(outPosAy), .outPosBx(outPosBx),
    .outPosBy(outPosBy), .outPosCx(outPosCx), .outPosCy(outPosCy),
    .outColA(outColA), .outColB(outColB), .outColC(outColC)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one triangle with side data derived from seq; returns the side data used
  task automatic drive(input logic [31:0] ya, yb, yc, output logic [263:0] side);
    @(negedge clk);
    seq++;
    inValid = 1'b1;
    posAy = ya; posBy = yb; posCy = yc;
    posAx = 32'h3E000000 + seq;
    posBx = 32'h3E100000 + seq * 3;
    posCx = 32'h3F100000 + seq * 7;
    colA  = {8'(seq), 8'hA5, 8'(~seq)};
    colB  = {8'h3C, 8'(seq * 5), 8'h11};
    colC  = {8'(seq + 9), 8'h7E, 8'(seq * 2)};
    side  = {posAx, posAy, posBx, posBy, posCx, posCy, colA, colB, colC};
  endtask

  task automatic checkOut(input string req, input int expCnt, input bit expErr,
                          input int expC, input logic [263:0] side);
    logic [263:0] got;
    got = {outPosAx, outPosAy, outPosBx, outPosBy, outPosCx, outPosCy, outColA, outColB, outColC};
    check(outValid == 1'b1, "R1", "outValid on fifth edge", outValid, 1);
    check(lineCount == 8'(expCnt), req, "lineCount", lineCount, expCnt);
    check(rangeErr == expErr, req, "rangeErr", rangeErr, expErr);
    if (expC >= 0) check(bottomIsC == expC[0], req, "bottomIsC", bottomIsC, expC);
    check(got[263:72] == side[263:72], "R2", "positions", got[95:64], side[95:64]);
    check(got[71:0] == side[71:0], "R2", "colours", got[71:0], side[71:0]);
  endtask

  // one isolated triangle, with latency checks around it
  task automatic runOne(input string req, input logic [31:0] ya, yb, yc,
                        input int expCnt, input bit expErr, input int expC);
    logic [263:0] side;
    drive(ya, yb, yc, side);
    @(negedge clk);
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid one cycle early", outValid, 0);
    @(negedge clk);
    checkOut(req, expCnt, expErr, expC, side);
    @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid one cycle late", outValid, 0);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R8", "outValid in reset", outValid, 0);
    check(lineCount == 8'd0, "R8", "lineCount in reset", lineCount, 0);
    check(rangeErr == 1'b0, "R8", "rangeErr in reset", rangeErr, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic testPick();
    runOne("R3", F0, F05, F075, 180, 1'b0, 1);
    runOne("R3", F0, F075, F05, 180, 1'b0, 0);
    runOne("R3", F025, F05, F05, 60, 1'b0, 0);
  endtask

  task automatic testSpans();
    runOne("R4", F025, F075, F05, 120, 1'b0, 0);
    runOne("R4", F0125, F0375, F0625, 120, 1'b0, 1);
    runOne("R4", F025, F0375, F025, 30, 1'b0, 0);
    runOne("R4", F0, F2M7, F0, 1, 1'b0, 0);
    runOne("R4", F0, F0125, F0, 30, 1'b0, 0);
  endtask

  task automatic testClamp();
    runOne("R5", F0, F1, F05, 240, 1'b0, 0);
    runOne("R5", F075, F025, F05, 0, 1'b0, 1);
    runOne("R5", F05, F05, F05, 0, 1'b0, 0);
  endtask

  task automatic testFlush();
    runOne("R6", FDEN1, F05, F0, 120, 1'b0, 0);
    runOne("R6", FNEG0, FDENM, F025, 60, 1'b0, 1);
    runOne("R6", F0, FNEG0, FDENM, 0, 1'b0, 0);
  endtask

  task automatic testBad();
    runOne("R7", FNAN, F05, F025, 0, 1'b1, -1);
    runOne("R7", F0, FINF, F025, 0, 1'b1, -1);
    runOne("R7", F0, F05, FOVER, 0, 1'b1, -1);
    runOne("R7", FM025, F05, F075, 0, 1'b1, -1);
  endtask

  task automatic testStream();
    logic [263:0] s0, s1, s2;
    drive(F0, F05, F025, s0);
    drive(F025, F025, F075, s1);
    drive(F0125, F0625, F0375, s2);
    @(negedge clk);
    inValid = 1'b0;
    repeat (2) @(negedge clk);
    checkOut("R1", 120, 1'b0, 0, s0);
    @(negedge clk);
    checkOut("R1", 120, 1'b0, 1, s1);
    @(negedge clk);
    checkOut("R2", 120, 1'b0, 0, s2);
    @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid after burst", outValid, 0);
  endtask

  initial begin
    testReset();
    testPick();
    testSpans();
    testClamp();
    testFlush();
    testBad();
    testStream();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule